// File: doc/BRIEF.md
# DRAM Bank State and Command Timing Tracker

This block follows the state of every bank in one DRAM device and tells a command scheduler, on each cycle, which command kinds may be sent to which bank. Every bank is either closed (precharged, no row held) or open (one row held in its row buffer). The scheduler offers at most one command per cycle, made up of a kind, a bank-group index, a bank index within that group and a row address. The tracker checks that command against the bank's state and against a set of minimum command spacings. A legal command updates the state. An illegal command is rejected and flagged.

All spacings are counted by small down-counters that are loaded when a command is accepted and that count toward zero. A spacing of N cycles means that a command accepted on clock edge t lets the guarded command through on edge t+N at the earliest. All timing values are elaboration parameters. Some spacings apply only within one bank group and others apply across the whole device, so each such rule has a per-group counter and a device-wide counter.

Top module: `dram_bank_tracker`

## Requirements
- R1: After a synchronous reset every bank is closed, every open-row field reads 0 and `cmd_error` is low. Activate is legal on every bank. Read, write and precharge are legal on none.
- R2: The command kind on `cmd_type` is encoded as 0 = activate, 1 = read, 2 = write and 3 = precharge. The flat bank number is group × banks-per-group + bank. An accepted activate marks its bank open from the next cycle, and that bank's `open_row` slice (bits b×ROW_W upward) then holds the supplied row.
- R3: An accepted activate or precharge occupies its bank for T_BUSY cycles (default 3). During that window every command kind to that bank is illegal. Banks that are not occupied stay usable, subject only to the spacing rules.
- R4: An accepted precharge closes its bank from the next cycle. A new activate to that bank becomes legal once the occupancy window has ended.
- R5: Two column commands (read or write) are separated by at least T_CCD_L cycles (default 6) within one bank group and by at least T_CCD_S cycles (default 4) across bank groups.
- R6: Two activates anywhere in the device are separated by at least T_RRD cycles (default 8).
- R7: A precharge to a bank is legal no sooner than T_RTP cycles (default 12) after the last read to that bank.
- R8: A read is legal no sooner than T_WTR_L cycles (default 16) after a write in the same bank group, and no sooner than T_WTR_S cycles (default 8) after a write in another group. Writes are not held back by this rule.
- R9: No more than FAW_ACTS activates (default 4) are accepted within any T_FAW-cycle window (default 32). An activate is therefore legal only once T_FAW cycles have passed since the FAW_ACTS-th most recent accepted activate.
- R10: Some commands are illegal: a read, write or precharge to a closed bank, an activate to an open bank, and any command that breaks an occupancy window or a spacing rule. An illegal valid command raises `cmd_error` on the next cycle and leaves all bank state and all counters unchanged. A legal command, or a cycle with no command, leaves `cmd_error` low on the next cycle.
- R11: An open bank accepts any number of reads and writes that meet the spacing rules. It stays open until a precharge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_type | input | 2 | Command kind: 0 activate, 1 read, 2 write, 3 precharge |
| cmd_group | input | GW | Bank-group index |
| cmd_bank | input | BW | Bank index within the group |
| cmd_row | input | ROW_W | Row address, used by activate |
| bank_active | output | NB | One bit per bank, set while the bank holds an open row |
| legal_act | output | NB | Activate would be accepted on this bank this cycle |
| legal_rd | output | NB | Read would be accepted on this bank this cycle |
| legal_wr | output | NB | Write would be accepted on this bank this cycle |
| legal_pre | output | NB | Precharge would be accepted on this bank this cycle |
| open_row | output | NB×ROW_W | Open row of every bank, bank b at bits b×ROW_W upward |
| cmd_error | output | 1 | The command of the previous cycle was rejected |

## Verification
The hardest condition to reach is the four-activate window acting as the only limit. With activate-to-activate spacing at its default of 8, four activates already take 24 cycles, so the fifth is held until cycle 32 by both rules at once and the window rule cannot be seen on its own. The bench therefore builds the tracker with activate spacing shortened to 6 cycles. It then issues four activates to one group at the minimum spacing, after an idle gap long enough that older activates have aged out of the window. A fifth activate tried at cycle 24 must be rejected, and it must become legal at exactly cycle 32. The write-to-read checks need a second group with an open bank, so that the short and long waits can be measured after a single write.

// File: rtl/dram_trk_pkg.sv
package dram_trk_pkg;
  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;
endpackage

// File: rtl/dram_bank_slot.sv
module dram_bank_slot
  import dram_trk_pkg::*;
#(
  parameter int ROW_W  = 16,
  parameter int T_BUSY = 3,
  parameter int T_RTP  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic [1:0]       cmd_type,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic             act_gate,
  input  logic             col_gate,
  input  logic             rd_gate,
  output logic             active,
  output logic [ROW_W-1:0] row,
  output logic             ok_act,
  output logic             ok_rd,
  output logic             ok_wr,
  output logic             ok_pre
);
  localparam int BCW = $clog2(T_BUSY + 1);
  localparam int RCW = $clog2(T_RTP + 1);

  logic [BCW-1:0] busy_q;
  logic [RCW-1:0] rtp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      row    <= '0;
      busy_q <= '0;
      rtp_q  <= '0;
    end else begin
      if (busy_q != '0) busy_q <= busy_q - 1'b1;
      if (rtp_q != '0)  rtp_q  <= rtp_q - 1'b1;
      if (hit) begin
        case (cmd_type)
          CMD_ACT: begin
            active <= 1'b1;
            row    <= cmd_row;
            busy_q <= BCW'(T_BUSY - 1);
          end
          CMD_RD:  rtp_q <= RCW'(T_RTP - 1);
          CMD_PRE: begin
            active <= 1'b0;
            busy_q <= BCW'(T_BUSY - 1);
          end
          default: ;
        endcase
      end
    end
  end

  logic free;
  assign free   = (busy_q == '0);
  assign ok_act = !active && free && act_gate;
  assign ok_wr  = active && free && col_gate;
  assign ok_rd  = active && free && col_gate && rd_gate;
  assign ok_pre = active && free && (rtp_q == '0);

  generate
    if (T_BUSY > 1) begin : g_busy_chk
      // R3: an opening or closing command locks the bank on the next cycle
      a_r3_bank_locked: assert property (@(posedge clk) disable iff (rst)
        (hit && (cmd_type == CMD_ACT || cmd_type == CMD_PRE))
          |=> !(ok_act || ok_rd || ok_wr || ok_pre));
    end
    if (T_RTP > 1) begin : g_rtp_chk
      a_r7_read_holds_pre: assert property (@(posedge clk) disable iff (rst)
        (hit && cmd_type == CMD_RD) |=> !ok_pre);
    end
  endgenerate

  a_r11_column_keeps_open: assert property (@(posedge clk) disable iff (rst)
    (hit && (cmd_type == CMD_RD || cmd_type == CMD_WR)) |=> active);
endmodule

// File: rtl/dram_spacing.sv
module dram_spacing #(
  parameter int GROUPS  = 4,
  parameter int T_CCD_S = 4,
  parameter int T_CCD_L = 6,
  parameter int T_RRD   = 8,
  parameter int T_WTR_S = 8,
  parameter int T_WTR_L = 16,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_issue,
  input  logic              col_issue,
  input  logic              wr_issue,
  input  logic [GW-1:0]     grp,
  output logic [GROUPS-1:0] col_ok,
  output logic [GROUPS-1:0] rd_ok,
  output logic              rrd_ok
);
  localparam int CW = $clog2(T_CCD_L + T_WTR_L + T_RRD + T_CCD_S + T_WTR_S + 1);

  logic [CW-1:0] ccd_any, wtr_any, rrd_q;
  logic [CW-1:0] ccd_grp [GROUPS];
  logic [CW-1:0] wtr_grp [GROUPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      ccd_any <= '0;
      wtr_any <= '0;
      rrd_q   <= '0;
    end else begin
      ccd_any <= col_issue ? CW'(T_CCD_S - 1) : (ccd_any != '0 ? ccd_any - 1'b1 : '0);
      wtr_any <= wr_issue  ? CW'(T_WTR_S - 1) : (wtr_any != '0 ? wtr_any - 1'b1 : '0);
      rrd_q   <= act_issue ? CW'(T_RRD - 1)   : (rrd_q   != '0 ? rrd_q   - 1'b1 : '0);
    end
  end

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic mine;
      assign mine = (grp == GW'(g));
      always_ff @(posedge clk) begin
        if (rst) begin
          ccd_grp[g] <= '0;
          wtr_grp[g] <= '0;
        end else begin
          ccd_grp[g] <= (col_issue && mine) ? CW'(T_CCD_L - 1)
                      : (ccd_grp[g] != '0 ? ccd_grp[g] - 1'b1 : '0);
          wtr_grp[g] <= (wr_issue && mine) ? CW'(T_WTR_L - 1)
                      : (wtr_grp[g] != '0 ? wtr_grp[g] - 1'b1 : '0);
        end
      end
      assign col_ok[g] = (ccd_any == '0) && (ccd_grp[g] == '0);
      assign rd_ok[g]  = (wtr_any == '0) && (wtr_grp[g] == '0);
    end
  endgenerate

  assign rrd_ok = (rrd_q == '0);

  generate
    if (T_RRD > 1) begin : g_rrd_chk
      a_r6_act_spacing: assert property (@(posedge clk) disable iff (rst)
        act_issue |=> !rrd_ok);
    end
    if (T_CCD_S > 1) begin : g_ccd_chk
      a_r5_column_spacing: assert property (@(posedge clk) disable iff (rst)
        col_issue |=> (col_ok == '0));
    end
    if (T_WTR_S > 1) begin : g_wtr_chk
      a_r8_write_to_read: assert property (@(posedge clk) disable iff (rst)
        wr_issue |=> (rd_ok == '0));
    end
  endgenerate
endmodule

// File: rtl/dram_faw_window.sv
module dram_faw_window #(
  parameter int T_FAW    = 32,
  parameter int FAW_ACTS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic act_issue,
  output logic faw_ok
);
  localparam int CW = $clog2(T_FAW + 1);
  localparam int PW = (FAW_ACTS > 1) ? $clog2(FAW_ACTS) : 1;

  logic [CW-1:0] slot [FAW_ACTS];
  logic [PW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (act_issue) begin
      ptr <= (ptr == PW'(FAW_ACTS - 1)) ? '0 : ptr + 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < FAW_ACTS; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) slot[i] <= '0;
        else if (act_issue && ptr == PW'(i)) slot[i] <= CW'(T_FAW - 1);
        else if (slot[i] != '0) slot[i] <= slot[i] - 1'b1;
      end
    end
  endgenerate

  assign faw_ok = (slot[ptr] == '0);

  // R9: an accepted activate never reuses a slot that is still counting
  a_r9_window_respected: assert property (@(posedge clk) disable iff (rst)
    act_issue |-> faw_ok);
endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
  import dram_trk_pkg::*;
#(
  parameter int GROUPS          = 4,
  parameter int BANKS_PER_GROUP = 4,
  parameter int ROW_W           = 16,
  parameter int T_BUSY          = 3,
  parameter int T_CCD_S         = 4,
  parameter int T_CCD_L         = 6,
  parameter int T_RRD           = 8,
  parameter int T_RTP           = 12,
  parameter int T_WTR_S         = 8,
  parameter int T_WTR_L         = 16,
  parameter int T_FAW           = 32,
  parameter int FAW_ACTS        = 4,
  localparam int NB = GROUPS * BANKS_PER_GROUP,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int BW = (BANKS_PER_GROUP > 1) ? $clog2(BANKS_PER_GROUP) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_type,
  input  logic [GW-1:0]       cmd_group,
  input  logic [BW-1:0]       cmd_bank,
  input  logic [ROW_W-1:0]    cmd_row,
  output logic [NB-1:0]       bank_active,
  output logic [NB-1:0]       legal_act,
  output logic [NB-1:0]       legal_rd,
  output logic [NB-1:0]       legal_wr,
  output logic [NB-1:0]       legal_pre,
  output logic [NB*ROW_W-1:0] open_row,
  output logic                cmd_error
);
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  logic [IW-1:0]     idx;
  logic              type_ok, accept;
  logic              act_issue, col_issue, wr_issue;
  logic              rrd_ok, faw_ok;
  logic [GROUPS-1:0] col_ok, rd_ok;

  assign idx = IW'(cmd_group) * IW'(BANKS_PER_GROUP) + IW'(cmd_bank);

  always_comb begin
    case (cmd_type)
      CMD_ACT: type_ok = legal_act[idx];
      CMD_RD:  type_ok = legal_rd[idx];
      CMD_WR:  type_ok = legal_wr[idx];
      default: type_ok = legal_pre[idx];
    endcase
  end

  assign accept    = cmd_valid && type_ok;
  assign act_issue = accept && (cmd_type == CMD_ACT);
  assign col_issue = accept && (cmd_type == CMD_RD || cmd_type == CMD_WR);
  assign wr_issue  = accept && (cmd_type == CMD_WR);

  always_ff @(posedge clk) begin
    if (rst) cmd_error <= 1'b0;
    else     cmd_error <= cmd_valid && !type_ok;
  end

  dram_spacing #(
    .GROUPS(GROUPS), .T_CCD_S(T_CCD_S), .T_CCD_L(T_CCD_L), .T_RRD(T_RRD),
    .T_WTR_S(T_WTR_S), .T_WTR_L(T_WTR_L)
  ) u_spacing (
    .clk(clk), .rst(rst), .act_issue(act_issue), .col_issue(col_issue),
    .wr_issue(wr_issue), .grp(cmd_group), .col_ok(col_ok), .rd_ok(rd_ok),
    .rrd_ok(rrd_ok)
  );

  dram_faw_window #(.T_FAW(T_FAW), .FAW_ACTS(FAW_ACTS)) u_faw (
    .clk(clk), .rst(rst), .act_issue(act_issue), .faw_ok(faw_ok)
  );

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      localparam int G = b / BANKS_PER_GROUP;
      dram_bank_slot #(.ROW_W(ROW_W), .T_BUSY(T_BUSY), .T_RTP(T_RTP)) u_slot (
        .clk(clk), .rst(rst),
        .hit(accept && idx == IW'(b)),
        .cmd_type(cmd_type), .cmd_row(cmd_row),
        .act_gate(rrd_ok && faw_ok),
        .col_gate(col_ok[G]),
        .rd_gate(rd_ok[G]),
        .active(bank_active[b]),
        .row(open_row[b*ROW_W +: ROW_W]),
        .ok_act(legal_act[b]), .ok_rd(legal_rd[b]),
        .ok_wr(legal_wr[b]), .ok_pre(legal_pre[b])
      );
    end
  endgenerate

  // R10: a rejected command is flagged and leaves bank state untouched
  a_r10_reject_flags: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !type_ok) |=> (cmd_error && $stable(bank_active)));
  a_r10_accept_clean: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && !type_ok) |=> !cmd_error);
  a_r2_open_after_act: assert property (@(posedge clk) disable iff (rst)
    act_issue |=> (bank_active != '0));
endmodule

// File: tb/test_dram_bank_tracker.sv
`timescale 1ns/1ps
module test_dram_bank_tracker;
  localparam int ROW_W = 16;
  localparam int NB    = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [1:0]        cmd_type = '0;
  logic [1:0]        cmd_group = '0;
  logic [1:0]        cmd_bank = '0;
  logic [ROW_W-1:0]  cmd_row = '0;
  logic [NB-1:0]     bank_active, legal_act, legal_rd, legal_wr, legal_pre;
  logic [NB*ROW_W-1:0] open_row;
  logic              cmd_error;

  always #2 clk = ~clk;

  // Activate spacing shortened so the four-activate window is visible on its own
  dram_bank_tracker #(.T_RRD(6)) i_dram_bank_tracker (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_group(cmd_group), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .bank_active(bank_active), .legal_act(legal_act), .legal_rd(legal_rd),
    .legal_wr(legal_wr), .legal_pre(legal_pre), .open_row(open_row),
    .cmd_error(cmd_error)
  );

  typedef struct {
    logic          err;
    logic [NB-1:0] act;
    string         req;
  } exp_t;

  exp_t          exp_q[$];
  logic [NB-1:0] model_act = '0;
  int            nchk = 0, nfail = 0;
  bit            done = 0;
  logic          samp = 1'b0;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Driver: called at a falling edge, occupies exactly one cycle
  task automatic issue(input int kind, input int grp, input int bnk,
                       input int row, input bit exp_err, input string req);
    exp_t e;
    int   flat;
    flat = grp * 4 + bnk;
    if (!exp_err) begin
      if (kind == 0) model_act[flat] = 1'b1;
      if (kind == 3) model_act[flat] = 1'b0;
    end
    e.err = exp_err; e.act = model_act; e.req = req;
    exp_q.push_back(e);
    cmd_valid = 1'b1;
    cmd_type  = 2'(kind);
    cmd_group = 2'(grp);
    cmd_bank  = 2'(bnk);
    cmd_row   = ROW_W'(row);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare the outcome of each sampled command
  always @(posedge clk) samp <= cmd_valid && !rst;
  always @(negedge clk) begin
    if (samp) begin
      exp_t e;
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", 1, 0);
      end else begin
        e = exp_q.pop_front();
        check({e.req, " cmd_error"}, 64'(cmd_error), 64'(e.err));
        check({e.req, " bank_active"}, 64'(bank_active), 64'(e.act));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 active", 64'(bank_active), 64'(0));
    check("R1 legal_act", 64'(legal_act), 64'hFFFF);
    check("R1 legal_rd", 64'(legal_rd), 64'(0));
    check("R1 legal_pre", 64'(legal_pre), 64'(0));
    check("R1 err", 64'(cmd_error), 64'(0));
    check("R1 row", 64'(open_row[15:0]), 64'(0));

    // R2 activate bank 0, time t
    issue(0, 0, 0, 'h123, 0, "R2 act b0");           // now t+1
    check("R2 open_row b0", 64'(open_row[15:0]), 64'h123);
    check("R3 busy rd b0 t+1", 64'(legal_rd[0]), 64'(0));
    idle(1);                                            // t+2
    check("R3 busy rd b0 t+2", 64'(legal_rd[0]), 64'(0));
    idle(1);                                            // t+3
    check("R3 rd b0 free t+3", 64'(legal_rd[0]), 64'(1));
    check("R6 act b4 held", 64'(legal_act[4]), 64'(0));
    idle(2);                                            // t+5
    check("R6 act b4 t+5", 64'(legal_act[4]), 64'(0));
    issue(0, 1, 0, 'h55, 1, "R10 early act b4");        // t+6
    check("R6 act b4 t+6", 64'(legal_act[4]), 64'(1));
    issue(0, 1, 0, 'h55, 0, "R6 act b4");               // t1=t+6, now t1+1
    check("R2 open_row b4", 64'(open_row[79:64]), 64'h55);

    // R5 column spacing: read b0 at r0
    issue(1, 0, 0, 0, 0, "R5 rd b0");                   // now r0+1
    idle(2);                                            // r0+3
    check("R5 rd b4 other grp r0+3", 64'(legal_rd[4]), 64'(0));
    idle(1);                                            // r0+4
    check("R5 rd b4 other grp r0+4", 64'(legal_rd[4]), 64'(1));
    check("R5 rd b0 same grp r0+4", 64'(legal_rd[0]), 64'(0));
    idle(1);                                            // r0+5
    check("R5 wr b0 same grp r0+5", 64'(legal_wr[0]), 64'(0));
    idle(1);                                            // r0+6
    check("R5 rd b0 same grp r0+6", 64'(legal_rd[0]), 64'(1));

    // R7 read to precharge
    idle(5);                                            // r0+11
    check("R7 pre b0 r0+11", 64'(legal_pre[0]), 64'(0));
    idle(1);                                            // r0+12
    check("R7 pre b0 r0+12", 64'(legal_pre[0]), 64'(1));
    issue(3, 0, 0, 0, 0, "R4 pre b0");                  // p0, now p0+1
    check("R4 act b0 busy p0+1", 64'(legal_act[0]), 64'(0));
    idle(1);                                            // p0+2
    check("R3 act b0 busy p0+2", 64'(legal_act[0]), 64'(0));
    idle(1);                                            // p0+3
    check("R4 act b0 p0+3", 64'(legal_act[0]), 64'(1));

    // R10 illegal commands
    issue(1, 0, 0, 0, 1, "R10 rd closed b0");           // p0+4
    issue(0, 1, 0, 'h77, 1, "R10 act open b4");         // p0+5
    check("R10 act b0 unchanged", 64'(legal_act[0]), 64'(1));
    check("R10 row b4 kept", 64'(open_row[79:64]), 64'h55);

    // R8 write to read
    issue(0, 2, 0, 7, 0, "R8 act b8");                  // a2, now a2+1
    idle(2);                                            // a2+3
    issue(2, 1, 0, 0, 0, "R11 wr b4");                  // w0, now w0+1
    idle(4);                                            // w0+5
    check("R5 wr b4 w0+5", 64'(legal_wr[4]), 64'(0));
    idle(1);                                            // w0+6
    check("R8 wr b4 not held w0+6", 64'(legal_wr[4]), 64'(1));
    idle(1);                                            // w0+7
    check("R8 rd b8 other grp w0+7", 64'(legal_rd[8]), 64'(0));
    idle(1);                                            // w0+8
    check("R8 rd b8 other grp w0+8", 64'(legal_rd[8]), 64'(1));
    idle(7);                                            // w0+15
    check("R8 rd b4 same grp w0+15", 64'(legal_rd[4]), 64'(0));
    idle(1);                                            // w0+16
    check("R8 rd b4 same grp w0+16", 64'(legal_rd[4]), 64'(1));
    issue(1, 1, 0, 0, 0, "R11 rd b4");
    check("R11 b4 still open", 64'(bank_active[4]), 64'(1));

    // R9 four-activate window
    idle(40);
    issue(0, 3, 0, 1, 0, "R9 act b12");                 // s
    idle(5);
    issue(0, 3, 1, 2, 0, "R9 act b13");                 // s+6
    idle(5);
    issue(0, 3, 2, 3, 0, "R9 act b14");                 // s+12
    idle(5);
    issue(0, 3, 3, 4, 0, "R9 act b15");                 // s+18
    idle(5);                                            // s+24
    check("R9 act b9 s+24", 64'(legal_act[9]), 64'(0));
    issue(0, 2, 1, 9, 1, "R9 fifth act early");         // now s+25
    idle(6);                                            // s+31
    check("R9 act b9 s+31", 64'(legal_act[9]), 64'(0));
    idle(1);                                            // s+32
    check("R9 act b9 s+32", 64'(legal_act[9]), 64'(1));
    issue(0, 2, 1, 9, 0, "R9 fifth act");
    check("R10 err clears", 64'(cmd_error), 64'(0));
    idle(2);
    check("R10 err idle", 64'(cmd_error), 64'(0));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule